// File: doc/BRIEF.md
# Unrolled AES-128 Round-Key Generator

This block turns a 128-bit cipher key into the ten AES-128 round keys, all at once and with no clock. It is a chain of ten identical expansion cells. Each cell takes the round key produced by the cell before it (the first one takes the cipher key itself) and produces the next round key. A round index, fixed as a parameter of each cell, selects that cell's round constant.

Every round key is a pure combinational function of the key input. A pipelined cipher datapath can therefore read all ten keys from one flattened 1280-bit bus, each round stage taking its own 128-bit slice. Changing the key input changes every slice after the combinational settling delay. The block stores no key and has no sequencing.

Top module: `aes128_keysched_unrolled`

## Requirements
- R1: Word 0 of round key r equals word 0 of round key r-1 XOR the transformed last word of round key r-1. The transform is a rotation, then byte substitution, then an XOR with the round constant. Round key 0 is the cipher key.
- R2: For words j = 1, 2 and 3, word j of round key r equals word j-1 of round key r XOR word j of round key r-1.
- R3: The rotation maps the bytes [b0,b1,b2,b3] of a word, with b0 the most significant byte, to [b1,b2,b3,b0]. Example: the last word 01020304 of an otherwise zero key gives round-1 word 0 = 767bf27c.
- R4: Byte substitution is the AES S-box, computed as the GF(2^8) inverse followed by the affine map with constant 63. Examples: S(00)=63, S(01)=7c, S(53)=ed. A zero key therefore gives round key 1 = 62636363 repeated four times.
- R5: The round constant for rounds 1 to 10 is 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. It sits in the most significant byte of the word, and the lower three bytes are zero. Example: a zero key gives round key 10 = b4ef5bcb 3e92e211 23e951cf 6f8f188e.
- R6: Round key r occupies bits [128*r-1 : 128*(r-1)] of the output bus. Word 0 is the most significant 32 bits of each slice. The cipher key is read the same way, with word 0 at bits [127:96].
- R7: For key 2b7e1516 28aed2a6 abf71588 09cf4f3c, round key 1 is a0fafe17 88542cb1 23a33939 2a6c7605 and round key 10 is d014f9a8 c9ee2589 e13f0cc8 b6630ca6.
- R8: All ten round keys follow a change of the key input in the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cipher_key_i | input | 128 | Cipher key, word 0 in the top 32 bits |
| round_keys_o | output | 1280 | Round keys 1..10, round 1 in the lowest 128 bits |

## Verification
A wrong byte in one cell's substitution, rotation or constant does not stay local. It moves into word 0 of that round and then spreads along the XOR chain into words 1 to 3. Every later round key then diverges as well, so the error shows as a mismatch in round key 10 for almost any key. An error in cell r shows first in slice r, in the same time step as the key change, because nothing in the block is registered. Comparing the full 1280-bit bus against an independent model for structured keys (zero, all ones, single-word keys) and pseudo-random keys exposes both where the error starts and how it spreads.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    localparam int WORD_W   = 32;
    localparam int NWORDS   = 4;
    localparam int BYTE_W   = 8;
    localparam int KEY_W    = WORD_W * NWORDS;
    localparam int WBYTES   = WORD_W / BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // w0 is the most significant word of a packed round key
    typedef struct packed {
        word_t w0;
        word_t w1;
        word_t w2;
        word_t w3;
    } rkey_t;

    // multiply by x in GF(2^8), reduction polynomial 0x11b
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // a^254 is the inverse for a != 0 and yields 0 for a == 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t res = 8'h01;
        byte_t pw  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i != 0) res = gf_mul(res, pw);
            pw = gf_mul(pw, pw);
        end
        return res;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_f(input byte_t a);
        byte_t v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // constant for round idx (1-based): x^(idx-1)
    function automatic byte_t rcon_f(input int idx);
        byte_t c = 8'h01;
        for (int i = 1; i < idx; i++) c = gf_xtime(c);
        return c;
    endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
    import aes_ks_pkg::*;
(
    input  byte_t in_i,
    output byte_t out_o
);

    assign out_o = sbox_f(in_i);

    // R4: the AES S-box has neither fixed points nor opposite fixed points
    always_comb begin
        if (!$isunknown(in_i)) begin
            a_r4_no_fixed_point: assert (out_o != in_i);
            a_r4_no_opposite_point: assert (out_o != ~in_i);
        end
    end

endmodule

// File: rtl/aes_ks_rotsub.sv
module aes_ks_rotsub
    import aes_ks_pkg::*;
(
    input  word_t word_i,
    output word_t sub_o
);

    word_t rot_w;

    // rotation by one byte is wiring only
    assign rot_w = {word_i[WORD_W-BYTE_W-1:0], word_i[WORD_W-1 -: BYTE_W]};

    for (genvar b = 0; b < WBYTES; b++) begin : g_sbox
        aes_ks_sbox u_sbox (
            .in_i  (rot_w[b*BYTE_W +: BYTE_W]),
            .out_o (sub_o[b*BYTE_W +: BYTE_W])
        );
    end

    // R3: the former top byte lands, substituted, in the lowest byte
    always_comb begin
        if (!$isunknown(word_i)) begin
            a_r3_top_to_bottom: assert (sub_o[BYTE_W-1:0] == sbox_f(word_i[WORD_W-1 -: BYTE_W]));
            a_r3_second_to_top: assert (sub_o[WORD_W-1 -: BYTE_W] == sbox_f(word_i[WORD_W-BYTE_W-1 -: BYTE_W]));
        end
    end

endmodule

// File: rtl/aes_ks_round_cell.sv
module aes_ks_round_cell
    import aes_ks_pkg::*;
#(
    parameter int ROUND_IDX = 1
) (
    input  rkey_t prev_i,
    output rkey_t next_o
);

    localparam byte_t RCON = rcon_f(ROUND_IDX);

    word_t sub_w;
    word_t mix_w;

    aes_ks_rotsub u_rotsub (
        .word_i (prev_i.w3),
        .sub_o  (sub_w)
    );

    assign mix_w     = sub_w ^ {RCON, {(WORD_W-BYTE_W){1'b0}}};
    assign next_o.w0 = prev_i.w0 ^ mix_w;
    assign next_o.w1 = next_o.w0 ^ prev_i.w1;
    assign next_o.w2 = next_o.w1 ^ prev_i.w2;
    assign next_o.w3 = next_o.w2 ^ prev_i.w3;

    // R2: each later word is recoverable from its neighbours
    always_comb begin
        if (!$isunknown(prev_i)) begin
            a_r2_chain_tail: assert ((next_o.w3 ^ next_o.w2) == prev_i.w3);
            a_r2_chain_head: assert ((next_o.w1 ^ next_o.w0) == prev_i.w1);
        end
    end

endmodule

// File: rtl/aes128_keysched_unrolled.sv
module aes128_keysched_unrolled
    import aes_ks_pkg::*;
#(
    parameter int NUM_ROUNDS = 10
) (
    input  logic [KEY_W-1:0]            cipher_key_i,
    output logic [NUM_ROUNDS*KEY_W-1:0] round_keys_o
);

    rkey_t chain_w [NUM_ROUNDS+1];

    assign chain_w[0] = rkey_t'(cipher_key_i);

    for (genvar r = 1; r <= NUM_ROUNDS; r++) begin : g_round
        aes_ks_round_cell #(.ROUND_IDX(r)) u_cell (
            .prev_i (chain_w[r-1]),
            .next_o (chain_w[r])
        );
        assign round_keys_o[r*KEY_W-1 -: KEY_W] = chain_w[r];
    end

endmodule

// File: tb/aes128_keysched_unrolled_tb_top.sv
module aes128_keysched_unrolled_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [127:0]    key;
    logic [NR*128-1:0] rks;

    int checks = 0;
    int failures = 0;

    aes128_keysched_unrolled dut_i (
        .cipher_key_i (key),
        .round_keys_o (rks)
    );

    // independent S-box: generated by walking the multiplicative group with generator 3
    logic [7:0] sb [256];
    initial begin
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b0};
            q = q ^ {q[3:0], 4'b0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    end

    function automatic logic [7:0] rc(input int r);
        case (r)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
            5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
            9: return 8'h1b;  default: return 8'h36;
        endcase
    endfunction

    function automatic logic [NR*128-1:0] model(input logic [127:0] k);
        logic [31:0] w [4];
        logic [31:0] t;
        logic [NR*128-1:0] o;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        o = '0;
        for (int r = 1; r <= NR; r++) begin
            t = {sb[w[3][23:16]], sb[w[3][15:8]], sb[w[3][7:0]], sb[w[3][31:24]]};
            w[0] = w[0] ^ t ^ {rc(r), 24'h0};
            w[1] = w[1] ^ w[0];
            w[2] = w[2] ^ w[1];
            w[3] = w[3] ^ w[2];
            o[r*128-1 -: 128] = {w[0], w[1], w[2], w[3]};
        end
        return o;
    endfunction

    task automatic check128(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [NR*128-1:0] exp;
        string             tag;
    } item_t;
    item_t sq [$];

    task automatic drive(input logic [127:0] k, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        key = k;
        it.exp = model(k);
        it.tag = tag;
        sq.push_back(it);
        @(negedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        if (sq.size() > 0) begin
            item_t it;
            it = sq.pop_front();
            for (int r = 1; r <= NR; r++)
                check128($sformatf("%s round%0d", it.tag, r),
                         rks[r*128-1 -: 128], it.exp[r*128-1 -: 128]);
        end
    end

    logic timed_out = 1'b0;
    logic [127:0] lfsr;

    initial begin
        key = '0;
        fork
            begin
                repeat (3) @(posedge clk);
                // reset state: zero key, known answers (R4, R5)
                @(negedge clk);
                check128("R4 zero key round1", rks[127:0], {4{32'h62636363}});
                check128("R5 zero key round10", rks[1279:1152],
                         128'hb4ef5bcb3e92e21123e951cf6f8f188e);
                check128("R4 all-ones key round1", model({128{1'b1}})[127:0],
                         128'he8e9e9e917161616e8e9e9e917161616);
                // R3 rotation order
                key = 128'h00000000_00000000_00000000_01020304;
                #1;
                check128("R3 rotation word0", {96'h0, rks[127:96]}, {96'h0, 32'h767bf27c});
                // R7 / R6 known vector and slice layout
                key = 128'h2b7e151628aed2a6abf7158809cf4f3c;
                #1;
                check128("R7 R6 round1 slice", rks[127:0], 128'ha0fafe1788542cb123a339392a6c7605);
                check128("R7 round10 slice", rks[1279:1152], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
                // R8 change without a clock edge
                key = '0;
                #1;
                check128("R8 no-clock update", rks[1279:1152], 128'hb4ef5bcb3e92e21123e951cf6f8f188e);
                // scoreboard items: R1 R2 full-bus comparisons
                drive('0, "R1 R2 zero");
                drive({128{1'b1}}, "R1 R2 ones");
                drive(128'h2b7e151628aed2a6abf7158809cf4f3c, "R7 vector");
                drive(128'hffffffff_00000000_00000000_00000000, "R2 word0 only");
                drive(128'h00000000_00000000_00000000_80000001, "R3 word3 edges");
                lfsr = 128'h0123456789abcdeffedcba9876543210;
                for (int i = 0; i < 20; i++) begin
                    lfsr = {lfsr[126:0], lfsr[127] ^ lfsr[125] ^ lfsr[100] ^ lfsr[98]};
                    lfsr = lfsr ^ (lfsr << 17) ^ (lfsr >> 29);
                    drive(lfsr, $sformatf("R1 R2 R5 random%0d", i));
                end
                repeat (2) @(posedge clk);
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule